// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Edge Interrupts

This block controls a bank of general-purpose I/O lines through a plain word-wide register port. Software chooses each line's direction. Each output line can be push-pull or open-drain. An output line drives the value last written to the data register. An input line's synchronised pin value is copied into the data register while that line's input-buffer enable is set. The pad side is three line-indexed vectors: `pad_out`, `pad_oe` and `pad_in`.

Each line also feeds an edge detector. The detector either reacts only to falling edges or to any change of the synchronised pin. A detected edge sets a sticky event bit. Software clears an event bit by writing a 1 to it. A mask register selects which event bits drive the single interrupt output `irq_out`. Reads have no side effects and return data in the same cycle. Register bits use reversed numbering: line n sits in bit 31−n.

Top module: `mgpio_bank`

## Requirements
- R1: After reset, the direction, open-drain, data, event, mask and edge-control registers read zero, the input-buffer-enable register reads all ones, `pad_oe` is zero and `irq_out` is low.
- R2: In every register, line n of the pad vectors corresponds to bit 31−n. For example, line 1 is bit 30 (0x40000000).
- R3: A direction bit of 1 makes a line an output, and a 0 makes it an input (`pad_oe` low). For a push-pull output, `pad_oe` is high and `pad_out` follows the line's data bit.
- R4: For an output line with its open-drain bit at 1: a data bit of 0 gives `pad_oe`=1 and `pad_out`=0; a data bit of 1 gives `pad_oe`=0.
- R5: Reading the data register returns, for output lines, the last value written to that bit, whatever the pin state.
- R6: For input lines, reading the data register returns the pin value seen through a two-flop synchroniser. A pin change becomes readable after the third rising clock edge. While the line's input-buffer-enable bit is 0, the bit keeps its last captured value.
- R7: With an edge-control bit of 0, both rising and falling pin changes set the line's event bit. The bit becomes readable after the third rising clock edge following the pin change.
- R8: With an edge-control bit of 1, only falling edges set the event bit, and rising edges are ignored.
- R9: Writing the event register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: When a new qualifying edge and a write-one clear hit the same event bit in the same cycle, the bit stays set.
- R11: `irq_out` is high exactly when some event bit and the matching mask bit are both 1.
- R12: Register offsets are direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, edge control 0x14 and input-buffer enable 0x18. These read back as written (events excepted). Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| pad_in | input | 32 | Pin input values, indexed by line |
| pad_out | output | 32 | Pin output values, indexed by line |
| pad_oe | output | 32 | Pin output enables, indexed by line |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The in-design assertions check several rules on every cycle:
- any qualifying edge leaves its event bit set on the next cycle, even when a clear lands on it at the same time;
- a clear without a competing edge empties the bit;
- a falling-only line never gains an event from a rise;
- clearing the direction or mask register immediately silences `pad_oe` or `irq_out`;
- unmapped offsets read zero.

Only the bench's scenarios can show the rest:
- the three-edge latency from pin to readback and to event;
- the reversed bit numbering;
- the open-drain drive pattern;
- holding of captured inputs while the buffer enable is off.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
    // Register byte offsets; software addresses these directly.
    localparam int unsigned OFS_DIR  = 'h00;
    localparam int unsigned OFS_ODR  = 'h04;
    localparam int unsigned OFS_DAT  = 'h08;
    localparam int unsigned OFS_EVT  = 'h0C;
    localparam int unsigned OFS_MSK  = 'h10;
    localparam int unsigned OFS_CTL  = 'h14;
    localparam int unsigned OFS_IBE  = 'h18;
endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_comb begin
            st_d[s] = st_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q[STAGES-1];
endmodule

// File: rtl/mgpio_evt.sv
module mgpio_evt #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] fall_only_i,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] clr_bits_i,
    output logic [WIDTH-1:0] evt_o
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] evt;
    } evt_st_t;

    evt_st_t st_d, st_q;
    logic [WIDTH-1:0] hit;

    always_comb begin
        // change on the line, restricted to high-to-low where falling-only
        hit = (st_q.prev ^ sync_i) & (~fall_only_i | st_q.prev);
        st_d      = st_q;
        st_d.prev = sync_i;
        // a fresh edge outranks a simultaneous clear
        st_d.evt  = (st_q.evt & ~(clr_i ? clr_bits_i : '0)) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign evt_o = st_q.evt;

    // R7, R10
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((evt_o & $past(hit)) == $past(hit)));

    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((evt_o & $past(clr_bits_i) & ~$past(hit)) == '0));

    // R8
    fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & ~$past(evt_o) & $past(fall_only_i)
          & ($past(sync_i) | ~$past(sync_i, 2))) == '0));
endmodule

// File: rtl/mgpio_bank.sv
module mgpio_bank
    import mgpio_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 32,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic                 irq_out
);
    localparam int unsigned LAST = NUM_LINES - 1;

    typedef struct packed {
        logic [NUM_LINES-1:0] dir;
        logic [NUM_LINES-1:0] odr;
        logic [NUM_LINES-1:0] dout;
        logic [NUM_LINES-1:0] din;
        logic [NUM_LINES-1:0] msk;
        logic [NUM_LINES-1:0] ctl;
        logic [NUM_LINES-1:0] ibe;
    } regs_t;

    localparam regs_t REGS_RST = '{dir: '0, odr: '0, dout: '0, din: '0,
                                   msk: '0, ctl: '0, ibe: '1};

    regs_t r_d, r_q;

    logic [NUM_LINES-1:0] pin_reg_order;   // pad_in in register bit order
    logic [NUM_LINES-1:0] sync_r;
    logic [NUM_LINES-1:0] evt_r;
    logic [NUM_LINES-1:0] drive_en_r, drive_val_r;
    logic                 evt_clr;
    logic                 addr_hit;

    // line n <-> register bit LAST-n
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_swap
        assign pin_reg_order[LAST-g] = pad_in[g];
        assign pad_oe[g]             = drive_en_r[LAST-g];
        assign pad_out[g]            = drive_val_r[LAST-g];
    end

    mgpio_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_reg_order),
        .sync_o  (sync_r)
    );

    assign evt_clr = bus_wr && (bus_addr == ADDR_W'(OFS_EVT));

    mgpio_evt #(.WIDTH(NUM_LINES)) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_r),
        .fall_only_i (r_q.ctl),
        .clr_i       (evt_clr),
        .clr_bits_i  (bus_wdata),
        .evt_o       (evt_r)
    );

    always_comb begin
        r_d = r_q;
        // capture synchronised pins only where the input buffer is on
        r_d.din = (r_q.ibe & sync_r) | (~r_q.ibe & r_q.din);
        if (bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFS_DIR): r_d.dir  = bus_wdata;
                ADDR_W'(OFS_ODR): r_d.odr  = bus_wdata;
                ADDR_W'(OFS_DAT): r_d.dout = bus_wdata;
                ADDR_W'(OFS_MSK): r_d.msk  = bus_wdata;
                ADDR_W'(OFS_CTL): r_d.ctl  = bus_wdata;
                ADDR_W'(OFS_IBE): r_d.ibe  = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFS_DIR): bus_rdata = r_q.dir;
            ADDR_W'(OFS_ODR): bus_rdata = r_q.odr;
            ADDR_W'(OFS_DAT): bus_rdata = (r_q.dir & r_q.dout) | (~r_q.dir & r_q.din);
            ADDR_W'(OFS_EVT): bus_rdata = evt_r;
            ADDR_W'(OFS_MSK): bus_rdata = r_q.msk;
            ADDR_W'(OFS_CTL): bus_rdata = r_q.ctl;
            ADDR_W'(OFS_IBE): bus_rdata = r_q.ibe;
            default:          bus_rdata = '0;
        endcase
    end

    // open-drain: drive low for 0, release for 1
    assign drive_en_r  = r_q.dir & ~(r_q.odr & r_q.dout);
    assign drive_val_r = r_q.dout & ~r_q.odr;
    assign irq_out     = |(evt_r & r_q.msk);

    assign addr_hit = (bus_addr == ADDR_W'(OFS_DIR)) || (bus_addr == ADDR_W'(OFS_ODR))
                   || (bus_addr == ADDR_W'(OFS_DAT)) || (bus_addr == ADDR_W'(OFS_EVT))
                   || (bus_addr == ADDR_W'(OFS_MSK)) || (bus_addr == ADDR_W'(OFS_CTL))
                   || (bus_addr == ADDR_W'(OFS_IBE));

    // R3
    dir_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_DIR) && bus_wdata == '0) |=> (pad_oe == '0));

    // R11
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_MSK) && bus_wdata == '0) |=> !irq_out);

    // R12
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |-> (bus_rdata == '0));
endmodule

// File: tb/mgpio_bank_tb.sv
module mgpio_bank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgpio_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    localparam logic [4:0] A_DIR = 5'h00, A_ODR = 5'h04, A_DAT = 5'h08,
                           A_EVT = 5'h0C, A_MSK = 5'h10, A_CTL = 5'h14,
                           A_IBE = 5'h18;

    function automatic logic [31:0] bm(int line);
        return 32'h1 << (31 - line);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_DIR, v); chk("R1 dir", v, 0);
        rd(A_ODR, v); chk("R1 odr", v, 0);
        rd(A_DAT, v); chk("R1 dat", v, 0);
        rd(A_EVT, v); chk("R1 evt", v, 0);
        rd(A_MSK, v); chk("R1 msk", v, 0);
        rd(A_CTL, v); chk("R1 ctl", v, 0);
        rd(A_IBE, v); chk("R1 ibe", v, 32'hFFFF_FFFF);
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 irq", {31'b0, irq_out}, 0);
    endtask

    task automatic t_push_pull;
        wr(A_DIR, bm(1) | bm(4));
        wr(A_DAT, bm(4));
        chk("R2 R3 pad_oe lines 1,4", pad_oe, 32'h12);
        chk("R2 R3 pad_out line 4", pad_out, 32'h10);
    endtask

    task automatic t_open_drain;
        wr(A_ODR, bm(1) | bm(4));
        chk("R4 od low drives", pad_oe, 32'h02);
        chk("R4 od out low", pad_out, 0);
        wr(A_DAT, bm(1));
        chk("R4 od swap oe", pad_oe, 32'h10);
        chk("R4 od swap out", pad_out, 0);
        wr(A_ODR, 0);
        wr(A_DIR, 0);
        chk("R3 inputs undriven", pad_oe, 0);
        wr(A_DAT, 0);
    endtask

    task automatic t_out_readback;
        logic [31:0] v;
        wr(A_DIR, bm(6));
        wr(A_DAT, bm(6) | bm(7));
        edges(4);
        rd(A_DAT, v);
        chk("R5 output shadow vs input pin", v & (bm(6) | bm(7)), bm(6));
        wr(A_DIR, 0);
        wr(A_DAT, 0);
    endtask

    task automatic t_in_sample;
        logic [31:0] v;
        pad_in[9] = 1'b1;
        edges(2);
        rd(A_DAT, v); chk("R6 not yet after 2 edges", v & bm(9), 0);
        edges(1);
        rd(A_DAT, v); chk("R6 visible after 3 edges", v & bm(9), bm(9));
        wr(A_IBE, ~bm(9));
        pad_in[9] = 1'b0;
        edges(4);
        rd(A_DAT, v); chk("R6 held while buffer off", v & bm(9), bm(9));
        wr(A_IBE, 32'hFFFF_FFFF);
        edges(1);
        rd(A_DAT, v); chk("R6 updates after re-enable", v & bm(9), 0);
        wr(A_EVT, 32'hFFFF_FFFF);
    endtask

    task automatic t_both_edges;
        logic [31:0] v;
        wr(A_EVT, 32'hFFFF_FFFF);
        pad_in[12] = 1'b1;
        edges(2);
        rd(A_EVT, v); chk("R7 rise not yet", v & bm(12), 0);
        edges(1);
        rd(A_EVT, v); chk("R7 rise sets", v, bm(12));
        wr(A_EVT, bm(12));
        rd(A_EVT, v); chk("R7 cleared", v, 0);
        pad_in[12] = 1'b0;
        edges(3);
        rd(A_EVT, v); chk("R7 fall sets", v, bm(12));
        wr(A_EVT, bm(12));
    endtask

    task automatic t_fall_only;
        logic [31:0] v;
        wr(A_CTL, bm(13));
        pad_in[13] = 1'b1;
        edges(4);
        rd(A_EVT, v); chk("R8 rise ignored", v, 0);
        pad_in[13] = 1'b0;
        edges(3);
        rd(A_EVT, v); chk("R8 fall sets", v, bm(13));
        wr(A_EVT, bm(13));
        wr(A_CTL, 0);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        pad_in[14] = 1'b1; pad_in[15] = 1'b1;
        edges(3);
        rd(A_EVT, v); chk("R9 two events", v, bm(14) | bm(15));
        wr(A_EVT, bm(14));
        rd(A_EVT, v); chk("R9 one cleared", v, bm(15));
        wr(A_EVT, 0);
        rd(A_EVT, v); chk("R9 zero write no effect", v, bm(15));
        wr(A_EVT, bm(15));
        rd(A_EVT, v); chk("R9 all cleared", v, 0);
    endtask

    task automatic t_clear_race;
        logic [31:0] v;
        pad_in[16] = 1'b1;
        edges(3);
        rd(A_EVT, v); chk("R10 setup", v, bm(16));
        pad_in[16] = 1'b0;
        repeat (2) @(posedge clk);
        wr(A_EVT, bm(16));
        rd(A_EVT, v); chk("R10 edge beats clear", v, bm(16));
        wr(A_EVT, bm(16));
        rd(A_EVT, v); chk("R10 later clear works", v, 0);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        pad_in[20] = 1'b1;
        edges(3);
        rd(A_EVT, v); chk("R11 event present", v, bm(20));
        chk("R11 masked off", {31'b0, irq_out}, 0);
        wr(A_MSK, bm(20));
        chk("R11 enabled", {31'b0, irq_out}, 1);
        wr(A_MSK, bm(21));
        chk("R11 other line only", {31'b0, irq_out}, 0);
        wr(A_MSK, bm(20));
        wr(A_EVT, bm(20));
        chk("R11 cleared drops irq", {31'b0, irq_out}, 0);
        wr(A_MSK, 0);
    endtask

    task automatic t_regmap;
        logic [31:0] v;
        wr(A_ODR, 32'h3C3C_3C3C);
        wr(A_MSK, 32'h5A5A_5A5A);
        wr(A_CTL, 32'hA5A5_A5A5);
        wr(A_IBE, 32'h0F0F_0F0F);
        wr(A_DIR, 32'h00FF_00FF);
        rd(A_ODR, v); chk("R12 odr", v, 32'h3C3C_3C3C);
        rd(A_MSK, v); chk("R12 msk", v, 32'h5A5A_5A5A);
        rd(A_CTL, v); chk("R12 ctl", v, 32'hA5A5_A5A5);
        rd(A_IBE, v); chk("R12 ibe", v, 32'h0F0F_0F0F);
        rd(A_DIR, v); chk("R12 dir", v, 32'h00FF_00FF);
        rd(5'h1C, v); chk("R12 unmapped 0x1C", v, 0);
        rd(5'h02, v); chk("R12 unaligned 0x02", v, 0);
        wr(A_DIR, 0); wr(A_ODR, 0); wr(A_MSK, 0); wr(A_CTL, 0);
        wr(A_IBE, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_pull();
        t_open_drain();
        t_out_readback();
        t_in_sample();
        t_both_edges();
        t_fall_only();
        t_w1c();
        t_clear_race();
        t_irq();
        t_regmap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule